// File: doc/BRIEF.md
# Data-Driven Burst Clock Enable

This block turns the arrival of a data item into a short, self-terminating train of clock-enable pulses. A sender offers a data word and a 4-bit cycle count on a valid/ready handshake. The block captures both, raises its enable for exactly that many cycles of the free-running reference clock, drops it, and then returns a one-cycle acknowledge. When no item is offered, the enable stays low.

A consumer gated by the enable sees the captured word on `data_out`. That word is registered before the first enable pulse. It does not change until the next item is accepted. The scheme is not pipelined: `in_ready` is high only while the block is idle, so the sender cannot disturb a running burst. The enable and the acknowledge each come straight from one bit of a one-hot state register. This gives clean, whole-cycle pulses with no partial pulse at either end of a burst.

Top module: `burst_clken`

## Requirements
- R1: While `rst_n` is low and after its release, the block is idle: `clk_en` = 0, `in_ack` = 0, `busy` = 0, `in_ready` = 1.
- R2: `in_ready` is high only while idle. Valid, data and count presented during a burst or acknowledge cycle are not accepted, and they change neither the pulse count nor `data_out`.
- R3: An item is accepted on a rising edge with `in_valid` and `in_ready` both high. If its count k (the 4-bit `in_count` field, unsigned 0..15) is nonzero, `clk_en` is high for exactly k consecutive cycles, starting in the cycle right after acceptance.
- R4: `in_ack` is high for exactly one cycle, the cycle after the last enable pulse. `in_ready` returns high in the cycle after that.
- R5: A count of zero gives no enable pulse. `in_ack` is high in the cycle right after acceptance.
- R6: `data_out` takes the accepted `in_data` in the cycle after acceptance. It holds that value until the next acceptance.
- R7: While idle with `in_valid` low, `clk_en` stays low.
- R8: `busy` is high from the cycle after acceptance through the acknowledge cycle, and low otherwise.
- R9: `clk_en` and `in_ack` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sender offers an item |
| in_ready | output | 1 | Block is idle and will accept an item |
| in_data | input | DATA_W | Data word of the offered item |
| in_count | input | CNT_W | Number of enable pulses for the item |
| data_out | output | DATA_W | Captured data word, stable for the burst |
| clk_en | output | 1 | Burst clock enable |
| busy | output | 1 | Burst or acknowledge in progress |
| in_ack | output | 1 | One-cycle completion acknowledge |

## Verification
Every count from 0 to 15 is sent back-to-back with a distinct data word. The bench checks each cycle's enable, acknowledge, busy and ready against values derived from k. This separates an off-by-one burst length, a late or early acknowledge, and wrong handling of zero. During each burst the bench drives a different word and count with valid held high. Any leak through the handshake would then show as a changed `data_out` or a wrong pulse total. A long idle stretch with valid low confirms that no enable appears without data.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // One-hot so each output is a single flop bit (no decode glitches).
  typedef enum logic [2:0] {
    ST_IDLE = 3'b001,
    ST_RUN  = 3'b010,
    ST_DONE = 3'b100
  } burst_state_e;

  localparam int unsigned RUN_BIT  = 1;
  localparam int unsigned DONE_BIT = 2;
  localparam int unsigned IDLE_BIT = 0;
endpackage

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         zero_k,
  input  logic         last,
  output burst_state_e state_q
);
  burst_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = zero_k ? ST_DONE : ST_RUN;
      ST_RUN:  if (last)   state_d = ST_DONE;
      ST_DONE:             state_d = ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/burst_clken.sv
module burst_clken
  import burst_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  output logic [DATA_W-1:0] data_out,
  output logic              clk_en,
  output logic              busy,
  output logic              in_ack
);
  burst_state_e state_q;
  logic         accept;
  logic         zero_k;
  logic         last;
  logic         running;

  assign in_ready = state_q[IDLE_BIT];
  assign running  = state_q[RUN_BIT];
  assign accept   = in_valid & in_ready;
  assign zero_k   = (in_count == '0);

  burst_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .zero_k  (zero_k),
    .last    (last),
    .state_q (state_q)
  );

  burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (in_count),
    .dec      (running),
    .last     (last)
  );

  burst_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .d     (in_data),
    .q     (data_out)
  );

  assign clk_en = state_q[RUN_BIT];
  assign in_ack = state_q[DONE_BIT];
  assign busy   = ~state_q[IDLE_BIT];
endmodule

// File: rtl/burst_clken_chk.sv
module burst_clken_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic [CNT_W-1:0]  in_count,
  input logic [DATA_W-1:0] data_out,
  input logic              clk_en,
  input logic              busy,
  input logic              in_ack
);
  logic [CNT_W:0]   seen_q;
  logic [CNT_W-1:0] want_q;
  logic             take;

  assign take = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      want_q <= '0;
    end else if (take) begin
      seen_q <= '0;
      want_q <= in_count;
    end else if (clk_en) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && busy));
  a_r3_pulse_total: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> (seen_q == {1'b0, want_q}));
  a_r4_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> in_ack);
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> (!in_ack && in_ready));
  a_r5_zero_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_count == '0) |=> (in_ack && !clk_en));
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(data_out));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !clk_en);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && in_ack));
endmodule

bind burst_clken burst_clken_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_burst_clken.sv
module test_burst_clken;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [DATA_W-1:0] in_data;
  logic [CNT_W-1:0]  in_count;
  logic [DATA_W-1:0] data_out;
  logic              clk_en;
  logic              busy;
  logic              in_ack;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  burst_clken #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_burst_clken (.*);

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Send one item and check every cycle until the block is ready again.
  task automatic send(input int k, input logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid = 1;
    in_data  = d;
    in_count = CNT_W'(k);
    for (int i = 1; i <= k + 2; i++) begin
      @(negedge clk);
      chk("R3", "clk_en", int'(clk_en), (i <= k) ? 1 : 0);
      chk("R4", "in_ack", int'(in_ack), (i == k + 1) ? 1 : 0);
      chk("R8", "busy", int'(busy), (i <= k + 1) ? 1 : 0);
      chk("R2", "in_ready", int'(in_ready), (i == k + 2) ? 1 : 0);
      chk("R6", "data_out", int'(data_out), int'(d));
      if (k == 0 && i == 1) chk("R5", "zero ack", int'(in_ack), 1);
      if (i == 1) begin
        // R2: junk offered during the burst must be ignored
        in_valid = 1;
        in_data  = ~d;
        in_count = CNT_W'(15 - k);
      end
      if (i == k + 1) in_valid = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 0;
    in_valid = 0;
    in_data = '0;
    in_count = '0;
    repeat (3) @(negedge clk);
    chk("R1", "clk_en in reset", int'(clk_en), 0);
    chk("R1", "in_ack in reset", int'(in_ack), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
    chk("R1", "clk_en after reset", int'(clk_en), 0);

    // R7: idle with no data, enable must stay low
    for (int i = 0; i < 8; i++) begin
      in_data = DATA_W'(i * 37);
      in_count = CNT_W'(i);
      @(negedge clk);
      chk("R7", "clk_en idle", int'(clk_en), 0);
      chk("R7", "busy idle", int'(busy), 0);
    end

    // R3/R4/R5/R6: sweep every count, ascending then descending
    for (int k = 0; k < 16; k++) send(k, DATA_W'((k * 29) ^ 8'hA5));
    for (int k = 15; k >= 0; k--) send(k, DATA_W'(k * 17 + 3));

    // R9: same-cycle exclusivity observed over one more burst
    @(negedge clk);
    in_valid = 1; in_count = 4'd2; in_data = 8'h3C;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 0;
      chk("R9", "en and ack together", int'(clk_en & in_ack), 0);
    end

    finish_run();
  end
endmodule